// File: doc/BRIEF.md
# Vector Element Address Generator

This block turns one vectorised load or store into a stream of effective addresses, one for each element. A start pulse captures the operation's settings: the vector length, the addressing mode, a scalar base value with a flag that forces the base to zero, a signed 16-bit displacement, the access size in bytes and a shift amount. The block then walks an element index from 0 up to the vector length minus one. For each element it offers the index and its address on a valid/ready handshake. After the last element has been accepted, it pulses a done signal.

There are three addressing modes. Unit stride steps by the access size from base plus displacement. Element stride uses the displacement itself as the step. The bit-reversed mode visits the scaled offsets in bit-reversed index order, which gives the data reordering an FFT butterfly needs. An extra left shift lets those offsets span radix-2 groups.

A three-state machine sequences the work. In ST_IDLE a start with a non-zero length moves to ST_EMIT and a start with zero length moves to ST_DONE. ST_EMIT stays put while ready is low, and advances the index on each accepted element. When the final element is accepted it moves to ST_DONE. ST_DONE always returns to ST_IDLE after one cycle.

Top module: `vlsu_agen`

## Requirements
- R1: While reset is asserted, and until a start is accepted, valid_o and done_o are low.
- R2: Mode code 0 (unit stride) gives address = B + sext(D) + size*i. Mode code 3 is reserved and behaves as unit stride.
- R3: Mode code 1 (element stride) gives address = B + sext(D)*i, and the access size has no effect on it.
- R4: Mode code 1 with a zero displacement falls back to unit-stride addressing.
- R5: B is base_i when base_zero_i is low and zero when it is high, in every mode.
- R6: Mode code 2 (bit-reversed) gives address = B + ((sext(D) * rev(i)) << shift), where rev reverses the low log2(VL) bits of i. VL is a power of two from 1 to 64. With VL=4 the offsets are used in the order 0,2,1,3.
- R7: In bit-reversed mode with VL=1, the single element has offset zero, so its address is B.
- R8: A start with VL=0 produces no valid element and raises done_o for exactly the next cycle.
- R9: valid_o rises in the cycle after an accepted start, with index 0. Each cycle with valid_o and ready_i high accepts one element, and the next element carries index+1.
- R10: While valid_o is high and ready_i is low, valid_o, idx_o and addr_o hold their values.
- R11: done_o is a one-cycle pulse in the cycle after element VL-1 is accepted, and valid_o is low during it.
- R12: A start, or a change to any setting input, while the block is not in ST_IDLE has no effect on the element stream in progress.
- R13: All address arithmetic is 64-bit and wraps modulo 2^64. The displacement is sign-extended from 16 bits before any multiply or add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins an operation when idle |
| vl_i | input | 7 | Vector length, 0 to 64 |
| mode_i | input | 2 | 0 unit, 1 element, 2 bit-reversed, 3 reserved (unit) |
| base_i | input | 64 | Scalar base value |
| base_zero_i | input | 1 | Use zero in place of base_i |
| disp_i | input | 16 | Signed displacement |
| size_i | input | 4 | Access size in bytes |
| shift_i | input | 6 | Left shift applied to the bit-reversed offset |
| ready_i | input | 1 | Consumer accepts the current element |
| valid_o | output | 1 | Element index and address are valid |
| done_o | output | 1 | One-cycle pulse when the operation ends |
| idx_o | output | 7 | Current element index |
| addr_o | output | 64 | Effective address of the current element |

## Verification
The bound checker watches the handshake and sequencing on every cycle. It checks that index and address hold while the element is stalled, that the index climbs by one per accepted element and starts at zero, that done is a single-cycle pulse that never overlaps valid, and that done only follows an accept or a start. Address values depend on the captured settings and the mode, so only the bench scenarios can show them. These scenarios compare the output against a behavioural model on every clock. They cover each mode, the zero-displacement fallback, the forced-zero base, the one- and zero-length cases, wrap-around with a negative displacement, and starts injected while the block is busy.

// File: rtl/vlsu_agen_pkg.sv
package vlsu_agen_pkg;

    typedef enum logic [1:0] {
        AM_UNIT = 2'd0,
        AM_ELEM = 2'd1,
        AM_BREV = 2'd2,
        AM_RSVD = 2'd3
    } am_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EMIT = 2'd1,
        ST_DONE = 2'd2
    } agu_state_e;

endpackage

// File: rtl/vlsu_agen_bitrev.sv
module vlsu_agen_bitrev #(
    parameter int REV_W = 6,
    parameter int LG_W  = 3
) (
    input  logic [REV_W-1:0] idx_i,
    input  logic [LG_W-1:0]  lg_i,
    output logic [REV_W-1:0] rev_o
);
    localparam logic [LG_W:0] FULL = (LG_W+1)'(REV_W);

    logic [REV_W-1:0] mirrored;
    logic [LG_W:0]    drop;

    // full-width mirror of the index, then keep only the low lg bits
    for (genvar k = 0; k < REV_W; k++) begin : g_mirror
        assign mirrored[k] = idx_i[REV_W-1-k];
    end

    assign drop  = FULL - {1'b0, lg_i};
    assign rev_o = mirrored >> drop;

endmodule

// File: rtl/vlsu_agen_addr.sv
module vlsu_agen_addr
    import vlsu_agen_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int IDX_W   = 7,
    parameter int REV_W   = 6,
    parameter int SIZE_W  = 4,
    parameter int SHIFT_W = 6
) (
    input  am_mode_e            mode_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [ADDR_W-1:0]   disp_i,
    input  logic [SIZE_W-1:0]   size_i,
    input  logic [SHIFT_W-1:0]  shift_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic [REV_W-1:0]    rev_i,
    output logic [ADDR_W-1:0]   addr_o
);
    logic [ADDR_W-1:0] offset;

    always_comb begin
        unique case (mode_i)
            AM_ELEM: offset = disp_i * ADDR_W'(idx_i);
            AM_BREV: offset = (disp_i * ADDR_W'(rev_i)) << shift_i;
            default: offset = disp_i + ADDR_W'(size_i) * ADDR_W'(idx_i);
        endcase
        addr_o = base_i + offset;
    end

endmodule

// File: rtl/vlsu_agen.sv
module vlsu_agen
    import vlsu_agen_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int DISP_W  = 16,
    parameter int MAX_VL  = 64,
    parameter int SIZE_W  = 4,
    parameter int SHIFT_W = 6,
    localparam int IDX_W  = $clog2(MAX_VL + 1),
    localparam int REV_W  = $clog2(MAX_VL),
    localparam int LG_W   = $clog2(REV_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [IDX_W-1:0]   vl_i,
    input  logic [1:0]         mode_i,
    input  logic [ADDR_W-1:0]  base_i,
    input  logic               base_zero_i,
    input  logic [DISP_W-1:0]  disp_i,
    input  logic [SIZE_W-1:0]  size_i,
    input  logic [SHIFT_W-1:0] shift_i,
    input  logic               ready_i,
    output logic               valid_o,
    output logic               done_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [ADDR_W-1:0]  addr_o
);
    agu_state_e state_q, state_d;

    logic [IDX_W-1:0]   idx_q, last_q;
    am_mode_e           mode_q;
    logic [ADDR_W-1:0]  base_q, disp_q;
    logic [SIZE_W-1:0]  size_q;
    logic [SHIFT_W-1:0] shift_q;
    logic [LG_W-1:0]    lg_q;

    logic               take_start, take_elem, last_elem;
    am_mode_e           mode_eff;
    logic [LG_W-1:0]    lg_in;
    logic [REV_W-1:0]   rev_idx;

    assign take_start = (state_q == ST_IDLE) && start_i;
    assign take_elem  = (state_q == ST_EMIT) && ready_i;
    assign last_elem  = (idx_q == last_q);

    // element stride needs a non-zero step; reserved code acts as unit stride
    always_comb begin
        unique case (am_mode_e'(mode_i))
            AM_ELEM: mode_eff = (disp_i == '0) ? AM_UNIT : AM_ELEM;
            AM_BREV: mode_eff = AM_BREV;
            default: mode_eff = AM_UNIT;
        endcase
    end

    // log2 of a power-of-two length: position of its highest set bit
    always_comb begin
        lg_in = '0;
        for (int k = 0; k < IDX_W; k++) begin
            if (vl_i[k]) lg_in = LG_W'(k);
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = (vl_i == '0) ? ST_DONE : ST_EMIT;
            ST_EMIT: if (ready_i && last_elem) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured settings and element counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            last_q  <= '0;
            mode_q  <= AM_UNIT;
            base_q  <= '0;
            disp_q  <= '0;
            size_q  <= '0;
            shift_q <= '0;
            lg_q    <= '0;
        end else if (take_start) begin
            idx_q   <= '0;
            last_q  <= vl_i - 1'b1;
            mode_q  <= mode_eff;
            base_q  <= base_zero_i ? '0 : base_i;
            disp_q  <= {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
            size_q  <= size_i;
            shift_q <= shift_i;
            lg_q    <= lg_in;
        end else if (take_elem && !last_elem) begin
            idx_q   <= idx_q + 1'b1;
        end
    end

    vlsu_agen_bitrev #(
        .REV_W (REV_W),
        .LG_W  (LG_W)
    ) u_bitrev (
        .idx_i (idx_q[REV_W-1:0]),
        .lg_i  (lg_q),
        .rev_o (rev_idx)
    );

    vlsu_agen_addr #(
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W),
        .REV_W   (REV_W),
        .SIZE_W  (SIZE_W),
        .SHIFT_W (SHIFT_W)
    ) u_addr (
        .mode_i  (mode_q),
        .base_i  (base_q),
        .disp_i  (disp_q),
        .size_i  (size_q),
        .shift_i (shift_q),
        .idx_i   (idx_q),
        .rev_i   (rev_idx),
        .addr_o  (addr_o)
    );

    // outputs
    always_comb begin
        valid_o = (state_q == ST_EMIT);
        done_o  = (state_q == ST_DONE);
        idx_o   = idx_q;
    end

endmodule

// File: rtl/vlsu_agen_chk.sv
module vlsu_agen_chk #(
    parameter int ADDR_W = 64,
    parameter int IDX_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              ready_i,
    input logic              valid_o,
    input logic              done_o,
    input logic [IDX_W-1:0]  idx_o,
    input logic [ADDR_W-1:0] addr_o
);
    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(idx_o) && $stable(addr_o)));

    // R9
    index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i) |=> (done_o || (valid_o && idx_o == $past(idx_o) + 1'b1)));

    // R9
    first_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> (idx_o == '0));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !valid_o));

    // R11
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && valid_o));

    // R8
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(valid_o && ready_i) || $past(start_i)));

endmodule

bind vlsu_agen vlsu_agen_chk #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .ready_i (ready_i),
    .valid_o (valid_o),
    .done_o  (done_o),
    .idx_o   (idx_o),
    .addr_o  (addr_o)
);

// File: tb/vlsu_agen_tb_top.sv
module vlsu_agen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [6:0]  vl_i = '0;
    logic [1:0]  mode_i = '0;
    logic [63:0] base_i = '0;
    logic        base_zero_i = 1'b0;
    logic [15:0] disp_i = '0;
    logic [3:0]  size_i = '0;
    logic [5:0]  shift_i = '0;
    logic        ready_i = 1'b0;
    logic        valid_o, done_o;
    logic [6:0]  idx_o;
    logic [63:0] addr_o;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    string cur_tag = "R1";

    // behavioural model state
    int m_phase = 0;   // 0 idle, 1 emitting, 2 done pulse
    int m_idx = 0;
    int m_vl = 0;
    longint unsigned m_q[$];

    always #4 clk = ~clk;

    vlsu_agen dut_i (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .vl_i (vl_i),
        .mode_i (mode_i), .base_i (base_i), .base_zero_i (base_zero_i),
        .disp_i (disp_i), .size_i (size_i), .shift_i (shift_i),
        .ready_i (ready_i), .valid_o (valid_o), .done_o (done_o),
        .idx_o (idx_o), .addr_o (addr_o)
    );

    function automatic longint unsigned ref_addr(int i, int vl, int mode,
            longint unsigned base, bit bz, logic [15:0] d, int size, int sh);
        longint b = bz ? 0 : longint'(base);
        longint ds = longint'($signed(d));   // R13 sign extension
        int lg = 0;
        int rev = 0;
        if (mode == 1 && d != 0) return longint'(b + ds * i);        // R3
        if (mode == 2) begin                                          // R6
            while ((1 << lg) < vl) lg++;
            for (int k = 0; k < lg; k++)
                if ((i >> k) & 1) rev |= 1 << (lg - 1 - k);
            return longint'(b + ((ds * rev) << sh));
        end
        return longint'(b + ds + longint'(size) * i);                 // R2, R4
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0;
            m_idx = 0;
        end else begin
            case (m_phase)
                0: if (start_i) begin
                    m_vl = int'(vl_i);
                    m_q.delete();
                    for (int i = 0; i < m_vl; i++)
                        m_q.push_back(ref_addr(i, m_vl, int'(mode_i), base_i,
                                      base_zero_i, disp_i, int'(size_i), int'(shift_i)));
                    m_idx = 0;
                    m_phase = (m_vl == 0) ? 2 : 1;
                end
                1: if (ready_i) begin
                    if (m_idx == m_vl - 1) m_phase = 2;
                    else m_idx++;
                end
                default: m_phase = 0;
            endcase
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        bit ev, ed, bad;
        longint unsigned ea;
        ev = (m_phase == 1);
        ed = (m_phase == 2);
        ea = ev ? m_q[m_idx] : 64'd0;
        bad = (valid_o !== ev) || (done_o !== ed) ||
              (ev && ((idx_o !== 7'(m_idx)) || (addr_o !== ea)));
        vectors++;
        if (bad) begin
            fails++;
            $display("FAIL %s: valid=%0b done=%0b idx=%0d addr=%h, expected valid=%0b done=%0b idx=%0d addr=%h",
                     cur_tag, valid_o, done_o, idx_o, addr_o, ev, ed, m_idx, ea);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // rpat: 0 always ready, 1 alternating, 2 pseudo-random
    task automatic run_job(string tag, int vl, int mode, longint unsigned base,
                           bit bz, logic [15:0] d, int size, int sh, int rpat, bit inject);
        int n = 0;
        @(negedge clk);
        cur_tag = tag;
        vl_i = 7'(vl); mode_i = 2'(mode); base_i = base; base_zero_i = bz;
        disp_i = d; size_i = 4'(size); shift_i = 6'(sh);
        start_i = 1'b1;
        ready_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (m_phase != 0) begin
            n++;
            case (rpat)
                0: ready_i = 1'b1;
                1: ready_i = n[0];
                default: ready_i = 1'($urandom_range(0, 1));
            endcase
            // R12: disturb settings and pulse start while busy
            if (inject && m_phase == 1) begin
                start_i = 1'b1;
                vl_i = 7'd3; mode_i = 2'd1; base_i = 64'hDEAD_0000;
                base_zero_i = ~bz; disp_i = 16'h0100; size_i = 4'd2; shift_i = 6'd5;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        ready_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state observed by the per-clock compare
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run_job("R3", 2, 1, 64'h10, 0, 16'd24, 4, 0, 0, 0);
        run_job("R3", 4, 1, 64'h10, 0, 16'd24, 8, 0, 1, 0);
        run_job("R2", 2, 0, 64'h10, 0, 16'd8, 4, 0, 0, 0);
        run_job("R10", 6, 0, 64'h1000, 0, 16'd2, 8, 0, 1, 0);
        run_job("R2", 5, 3, 64'h200, 0, 16'd4, 2, 0, 2, 0);
        run_job("R4", 3, 1, 64'h80, 0, 16'd0, 8, 0, 0, 0);
        run_job("R5", 4, 1, 64'hFFFF_0000, 1, 16'd12, 4, 0, 0, 0);
        run_job("R5", 4, 2, 64'hFFFF_0000, 1, 16'd4, 4, 1, 0, 0);
        run_job("R6", 4, 2, 64'h10, 0, 16'd4, 4, 0, 0, 0);
        run_job("R6", 8, 2, 64'h100, 0, 16'd8, 8, 2, 2, 0);
        run_job("R7", 1, 2, 64'h40, 0, 16'd100, 4, 3, 0, 0);
        run_job("R8", 0, 0, 64'h40, 0, 16'd4, 4, 0, 0, 0);
        run_job("R13", 4, 0, 64'hFFFF_FFFF_FFFF_FFF0, 0, 16'hFFF8, 8, 0, 0, 0);
        run_job("R13", 64, 2, 64'h8, 0, 16'h8000, 4, 1, 2, 0);
        run_job("R9", 64, 1, 64'h0, 0, 16'hFFFC, 4, 0, 2, 0);
        run_job("R12", 5, 0, 64'h300, 0, 16'd16, 4, 0, 1, 1);
        run_job("R11", 2, 2, 64'h300, 0, 16'd16, 4, 0, 0, 1);
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule